// File: doc/BRIEF.md
# Parallel Bitstream Loader

This block is the master side of an 8-bit parallel slave configuration port on a programmable target device. Once a start pulse arrives, it holds the target's program pin low and watches for the init pin to answer low. It then releases the program pin and waits for init to go high again. Next it asserts chip select and the write strobe and lets the port settle. After that it takes bitstream bytes from a valid/ready stream and clocks each one into the target with a low-then-high configuration clock. When the load is over, it releases chip select first and the write strobe after it, and checks that the target reports completion.

Each phase that waits on the target has its own limit. The limits are given in milliseconds or nanoseconds and turned into system clock cycles from a clock frequency parameter. Before each byte the block checks two things. A done indication ends the load early. A low init pin means the target found a bitstream error, so the block aborts and records how many bytes had already been clocked in. When busy checking is enabled, the block also pauses after each byte while the target's busy pin is high. The outcome is held on sticky status outputs until the next start: success, or an error with a 3-bit cause code.

Top module: `pcfg_loader`

## Requirements
- R1: After reset and whenever idle, tgt_prog_n, tgt_sel_n, tgt_wr_n and tgt_cclk are high, s_ready is low and active is low. After reset cfg_ok and cfg_err are also low.
- R2: A start pulse drives tgt_prog_n low. It stays low for at least PROG_CYC cycles and until tgt_init_n has been seen low. If tgt_init_n is not low within INIT_CYC cycles, tgt_prog_n is released after exactly INIT_CYC cycles and the run fails with code 1.
- R3: After tgt_prog_n is released, the block waits up to INIT_CYC cycles for tgt_init_n to go high. If it does not, the run fails with code 2.
- R4: tgt_sel_n and tgt_wr_n go low together. Exactly SETTLE_CYC cycles then pass before s_ready first rises.
- R5: s_ready is high only while the block waits for a byte. An accepted byte is driven on tgt_d. tgt_cclk is then low for exactly CCLK_LO_CYC cycles and then high, and tgt_d holds while tgt_cclk is low and at its rise.
- R6: If tgt_done is high when the next byte is due, no further byte is accepted. The block goes straight to the completion check and can end with cfg_ok.
- R7: If tgt_init_n is low when the next byte is due, the run fails with code 3, no further byte is accepted, and err_offset equals the number of bytes already clocked in.
- R8: With CHECK_BUSY set, no byte is accepted while tgt_busy is high after a clock rise. If tgt_busy stays high for BUSY_CYC cycles, the run fails with code 4.
- R9: After the last byte, or after an early done, tgt_sel_n rises exactly one cycle before tgt_wr_n.
- R10: After the release, tgt_done high together with tgt_init_n high within DONE_CYC cycles gives cfg_ok = 1 with err_code 0. Otherwise the run fails with code 5.
- R11: On any failure, tgt_prog_n, tgt_sel_n and tgt_wr_n return high and cfg_err is set with a nonzero err_code. Status holds while idle and is cleared when the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run (taken only when idle) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DATA_W | Stream byte |
| s_last | input | 1 | Marks the final byte of the bitstream |
| s_ready | output | 1 | Block can take a byte this cycle |
| tgt_prog_n | output | 1 | Target program pin, active low |
| tgt_cclk | output | 1 | Target configuration clock |
| tgt_sel_n | output | 1 | Target chip select, active low |
| tgt_wr_n | output | 1 | Target write strobe, active low |
| tgt_d | output | DATA_W | Target configuration data bus |
| tgt_init_n | input | 1 | Target init pin, low = clearing or error |
| tgt_done | input | 1 | Target done pin |
| tgt_busy | input | 1 | Target busy pin |
| active | output | 1 | A run is in progress |
| cfg_ok | output | 1 | Last run completed successfully (sticky) |
| cfg_err | output | 1 | Last run failed (sticky) |
| err_code | output | 3 | Failure cause: 1 no init low, 2 init high timeout, 3 bitstream error, 4 busy timeout, 5 done timeout |
| err_offset | output | OFS_W | Bytes clocked in when the failure was recorded |

## Verification
A stuck or wrong sequencer state shows at the pins within one cycle: s_ready rising while chip select is still high, the write strobe rising before chip select, or the data bus changing during a low clock phase. Each of these breaks a pin-level property on the next edge. Wrong phase limits show as a program pulse, a settle gap or a clock-low width that is a cycle off, and the bench counts these against the parameter values. A wrong failure path shows as a wrong cause code, a byte offset that does not match the bytes the bench saw clocked in, or a byte accepted after done, init low or busy should have stopped the stream.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITW,
    ST_SETTLE,
    ST_FETCH,
    ST_CLO,
    ST_CHI,
    ST_BUSYW,
    ST_RELSEL,
    ST_DONEW
  } seq_st_e;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_NO_INIT_LOW  = 3'd1,
    ERR_INIT_HIGH_TO = 3'd2,
    ERR_BITSTREAM    = 3'd3,
    ERR_BUSY_TO      = 3'd4,
    ERR_DONE_TO      = 3'd5
  } err_code_e;

  typedef struct packed {
    logic prog_n;
    logic cclk;
    logic sel_n;
    logic wr_n;
  } pin_s;

  // Milliseconds to system clock cycles, at least one cycle.
  function automatic int unsigned ms_to_cyc(input int unsigned khz, input int unsigned ms);
    longint unsigned p;
    p = 64'(khz) * 64'(ms);
    if (p == 64'd0) p = 64'd1;
    return p[31:0];
  endfunction

  // Nanoseconds to system clock cycles, rounded up, at least one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned khz, input int unsigned ns);
    longint unsigned p;
    p = (64'(ns) * 64'(khz) + 64'd999_999) / 64'd1_000_000;
    if (p == 64'd0) p = 64'd1;
    return p[31:0];
  endfunction

  // Pin levels each sequencer state presents to the target.
  function automatic pin_s pins_for(input seq_st_e s);
    pin_s p;
    p.prog_n = (s != ST_PROG);
    p.cclk   = (s != ST_CLO);
    p.sel_n  = !(s == ST_SETTLE || s == ST_FETCH || s == ST_CLO ||
                 s == ST_CHI || s == ST_BUSYW);
    p.wr_n   = !(s == ST_SETTLE || s == ST_FETCH || s == ST_CLO ||
                 s == ST_CHI || s == ST_BUSYW || s == ST_RELSEL);
    return p;
  endfunction

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] elapsed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  elapsed <= '0;
    else if (restart)            elapsed <= '0;
    else if (elapsed != '1)      elapsed <= elapsed + 1'b1;
  end

  // R2 R3 R8 R10: every phase limit counts from zero on phase entry
  a_r2_timer_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (elapsed == '0));

endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned OFS_W       = 24,
  parameter int unsigned PROG_C      = 30,
  parameter int unsigned INIT_C      = 50_000_000,
  parameter int unsigned SETTLE_C    = 1_000_000,
  parameter int unsigned CLO_C       = 2,
  parameter int unsigned CHI_C       = 2,
  parameter int unsigned BUSY_C      = 500_000,
  parameter int unsigned DONE_C      = 20_000_000,
  parameter bit          CHECK_BUSY  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tgt_prog_n,
  output logic              tgt_cclk,
  output logic              tgt_sel_n,
  output logic              tgt_wr_n,
  output logic [DATA_W-1:0] tgt_d,
  input  logic              tgt_init_n,
  input  logic              tgt_done,
  input  logic              tgt_busy,
  input  logic [CNT_W-1:0]  elapsed,
  output logic              phase_change,
  output logic              active,
  output logic              cfg_ok,
  output logic              cfg_err,
  output logic [2:0]        err_code,
  output logic [OFS_W-1:0]  err_offset
);

  localparam logic [CNT_W-1:0] L_PROG   = CNT_W'(PROG_C - 1);
  localparam logic [CNT_W-1:0] L_INIT   = CNT_W'(INIT_C - 1);
  localparam logic [CNT_W-1:0] L_SETTLE = CNT_W'(SETTLE_C - 1);
  localparam logic [CNT_W-1:0] L_CLO    = CNT_W'(CLO_C - 1);
  localparam logic [CNT_W-1:0] L_CHI    = CNT_W'(CHI_C - 1);
  localparam logic [CNT_W-1:0] L_BUSY   = CNT_W'(BUSY_C - 1);
  localparam logic [CNT_W-1:0] L_DONE   = CNT_W'(DONE_C - 1);

  seq_st_e          st, st_d;
  err_code_e        fail_code, code_q;
  pin_s             pins_q;
  logic             fail, finish_ok, accept, busy_stall, last_q;
  logic             byte_due, early_done, bit_error;
  logic [OFS_W-1:0] byte_cnt;

  // Named phase events, used by the next-state logic and the checks
  logic t_prog_min, t_init, t_settle, t_clo, t_chi, t_busy, t_done;
  assign t_prog_min = (elapsed >= L_PROG);
  assign t_init     = (elapsed >= L_INIT);
  assign t_settle   = (elapsed >= L_SETTLE);
  assign t_clo      = (elapsed >= L_CLO);
  assign t_chi      = (elapsed >= L_CHI);
  assign t_busy     = (elapsed >= L_BUSY);
  assign t_done     = (elapsed >= L_DONE);

  generate
    if (CHECK_BUSY) begin : g_busy
      assign busy_stall = tgt_busy;
    end else begin : g_nobusy
      assign busy_stall = 1'b0;
    end
  endgenerate

  assign byte_due   = (st == ST_FETCH);
  assign early_done = byte_due && tgt_done;
  assign bit_error  = byte_due && !tgt_done && !tgt_init_n;
  assign s_ready    = byte_due && !tgt_done && tgt_init_n;
  assign accept     = s_ready && s_valid;

  always_comb begin
    st_d      = st;
    fail      = 1'b0;
    fail_code = ERR_NONE;
    finish_ok = 1'b0;
    unique case (st)
      ST_IDLE:   if (start) st_d = ST_PROG;
      ST_PROG: begin
        if (!tgt_init_n && t_prog_min) st_d = ST_INITW;
        else if (t_init) begin fail = 1'b1; fail_code = ERR_NO_INIT_LOW; end
      end
      ST_INITW: begin
        if (tgt_init_n) st_d = ST_SETTLE;
        else if (t_init) begin fail = 1'b1; fail_code = ERR_INIT_HIGH_TO; end
      end
      ST_SETTLE: if (t_settle) st_d = ST_FETCH;
      ST_FETCH: begin
        if (early_done)     st_d = ST_RELSEL;
        else if (bit_error) begin fail = 1'b1; fail_code = ERR_BITSTREAM; end
        else if (s_valid)   st_d = ST_CLO;
      end
      ST_CLO:    if (t_clo) st_d = ST_CHI;
      ST_CHI:    if (t_chi) st_d = ST_BUSYW;
      ST_BUSYW: begin
        if (!busy_stall) st_d = last_q ? ST_RELSEL : ST_FETCH;
        else if (t_busy) begin fail = 1'b1; fail_code = ERR_BUSY_TO; end
      end
      ST_RELSEL: st_d = ST_DONEW;
      ST_DONEW: begin
        if (tgt_done && tgt_init_n) begin finish_ok = 1'b1; st_d = ST_IDLE; end
        else if (t_done) begin fail = 1'b1; fail_code = ERR_DONE_TO; end
      end
      default:   st_d = ST_IDLE;
    endcase
    if (fail) st_d = ST_IDLE;
  end

  assign phase_change = (st_d != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pins_q     <= '{prog_n: 1'b1, cclk: 1'b1, sel_n: 1'b1, wr_n: 1'b1};
      tgt_d      <= '0;
      last_q     <= 1'b0;
      byte_cnt   <= '0;
      cfg_ok     <= 1'b0;
      cfg_err    <= 1'b0;
      code_q     <= ERR_NONE;
      err_offset <= '0;
    end else begin
      st     <= st_d;
      pins_q <= pins_for(st_d);
      if (st == ST_IDLE && start) begin
        cfg_ok     <= 1'b0;
        cfg_err    <= 1'b0;
        code_q     <= ERR_NONE;
        err_offset <= '0;
        byte_cnt   <= '0;
        last_q     <= 1'b0;
      end
      if (accept) begin
        tgt_d    <= s_data;
        last_q   <= s_last;
        byte_cnt <= byte_cnt + 1'b1;
      end
      if (fail) begin
        cfg_err    <= 1'b1;
        code_q     <= fail_code;
        err_offset <= byte_cnt;
      end
      if (finish_ok) cfg_ok <= 1'b1;
    end
  end

  assign tgt_prog_n = pins_q.prog_n;
  assign tgt_cclk   = pins_q.cclk;
  assign tgt_sel_n  = pins_q.sel_n;
  assign tgt_wr_n   = pins_q.wr_n;
  assign active     = (st != ST_IDLE);
  assign err_code   = code_q;

  // R1: idle means every target strobe released and no stream demand
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (tgt_prog_n && tgt_sel_n && tgt_wr_n && tgt_cclk && !s_ready));

  // R5: a byte is only taken with the port selected, writing, clock high
  a_r5_ready_port: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!tgt_sel_n && !tgt_wr_n && tgt_cclk && tgt_prog_n));

  // R5: data holds through the low clock phase and across the rise
  a_r5_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tgt_cclk) |-> $stable(tgt_d));

  // R9: on a normal release, chip select is already high when the strobe rises
  a_r9_sel_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tgt_wr_n) && !cfg_err) |-> $past(tgt_sel_n));

  // R11: a failure always carries a cause and success never does
  a_r11_err_code: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (err_code != 3'd0 && !cfg_ok));
  a_r10_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (err_code == 3'd0));

  // R8: no byte enters while the target reports busy after a clock rise
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BUSYW && busy_stall) |=> (st != ST_CLO));

endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned OFS_W       = 24,
  parameter int unsigned CLK_KHZ     = 100_000,
  parameter int unsigned PROG_NS     = 300,
  parameter int unsigned INIT_MS     = 500,
  parameter int unsigned SETTLE_MS   = 10,
  parameter int unsigned BUSY_MS     = 5,
  parameter int unsigned DONE_MS     = 200,
  parameter int unsigned CCLK_LO_CYC = 2,
  parameter int unsigned CCLK_HI_CYC = 2,
  parameter bit          CHECK_BUSY  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  output logic              s_ready,
  output logic              tgt_prog_n,
  output logic              tgt_cclk,
  output logic              tgt_sel_n,
  output logic              tgt_wr_n,
  output logic [DATA_W-1:0] tgt_d,
  input  logic              tgt_init_n,
  input  logic              tgt_done,
  input  logic              tgt_busy,
  output logic              active,
  output logic              cfg_ok,
  output logic              cfg_err,
  output logic [2:0]        err_code,
  output logic [OFS_W-1:0]  err_offset
);

  localparam int unsigned PROG_C   = ns_to_cyc(CLK_KHZ, PROG_NS);
  localparam int unsigned INIT_C   = ms_to_cyc(CLK_KHZ, INIT_MS);
  localparam int unsigned SETTLE_C = ms_to_cyc(CLK_KHZ, SETTLE_MS);
  localparam int unsigned BUSY_C   = ms_to_cyc(CLK_KHZ, BUSY_MS);
  localparam int unsigned DONE_C   = ms_to_cyc(CLK_KHZ, DONE_MS);
  localparam int unsigned CLO_C    = (CCLK_LO_CYC == 0) ? 1 : CCLK_LO_CYC;
  localparam int unsigned CHI_C    = (CCLK_HI_CYC == 0) ? 1 : CCLK_HI_CYC;

  logic [CNT_W-1:0] elapsed;
  logic             phase_change;

  pcfg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_change),
    .elapsed (elapsed)
  );

  pcfg_seq #(
    .DATA_W     (DATA_W),
    .CNT_W      (CNT_W),
    .OFS_W      (OFS_W),
    .PROG_C     (PROG_C),
    .INIT_C     (INIT_C),
    .SETTLE_C   (SETTLE_C),
    .CLO_C      (CLO_C),
    .CHI_C      (CHI_C),
    .BUSY_C     (BUSY_C),
    .DONE_C     (DONE_C),
    .CHECK_BUSY (CHECK_BUSY)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .s_valid      (s_valid),
    .s_data       (s_data),
    .s_last       (s_last),
    .s_ready      (s_ready),
    .tgt_prog_n   (tgt_prog_n),
    .tgt_cclk     (tgt_cclk),
    .tgt_sel_n    (tgt_sel_n),
    .tgt_wr_n     (tgt_wr_n),
    .tgt_d        (tgt_d),
    .tgt_init_n   (tgt_init_n),
    .tgt_done     (tgt_done),
    .tgt_busy     (tgt_busy),
    .elapsed      (elapsed),
    .phase_change (phase_change),
    .active       (active),
    .cfg_ok       (cfg_ok),
    .cfg_err      (cfg_err),
    .err_code     (err_code),
    .err_offset   (err_offset)
  );

endmodule

// File: tb/pcfg_loader_tb.sv
module pcfg_loader_tb;

  localparam int CLK_PERIOD = 10;
  // 10 cycles per ms: init 40, settle 10, busy 10, done 30, program pulse 5
  localparam int KHZ      = 10;
  localparam int PROG_CYC = 5;
  localparam int INIT_CYC = 40;
  localparam int SET_CYC  = 10;
  localparam int LO_CYC   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_last = 1'b0;
  logic       tgt_init_n = 1'b1;
  logic       tgt_done = 1'b0;
  logic       tgt_busy = 1'b0;
  logic       s_ready, tgt_prog_n, tgt_cclk, tgt_sel_n, tgt_wr_n;
  logic [7:0] tgt_d;
  logic       active, cfg_ok, cfg_err;
  logic [2:0] err_code;
  logic [23:0] err_offset;

  int checks = 0;
  int errors = 0;
  int cap_total = 0;
  int stall_bad = 0;
  int lo_meas = 0;
  logic [7:0] cap [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcfg_loader #(
    .CLK_KHZ(KHZ), .PROG_NS(500_000), .INIT_MS(4), .SETTLE_MS(1),
    .BUSY_MS(1), .DONE_MS(3), .CCLK_LO_CYC(LO_CYC), .CCLK_HI_CYC(2),
    .CHECK_BUSY(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .tgt_prog_n(tgt_prog_n), .tgt_cclk(tgt_cclk), .tgt_sel_n(tgt_sel_n),
    .tgt_wr_n(tgt_wr_n), .tgt_d(tgt_d), .tgt_init_n(tgt_init_n),
    .tgt_done(tgt_done), .tgt_busy(tgt_busy), .active(active),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err), .err_code(err_code),
    .err_offset(err_offset)
  );

  // Target-side capture of every byte clocked in
  always @(posedge tgt_cclk) begin
    if (rst_n && !tgt_sel_n && !tgt_wr_n) begin
      cap[cap_total % 64] = tgt_d;
      cap_total = cap_total + 1;
    end
  end

  // A handshake armed while busy is high is a stall violation
  always @(negedge clk) begin
    if (rst_n && s_valid && s_ready && tgt_busy) stall_bad = stall_bad + 1;
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    step(); start = 1'b1;
    step(); start = 1'b0;
  endtask

  // Program phase as the target sees it; returns cycles with program low
  task automatic prog_phase(input bit drop, input bit rise, output int low);
    int g;
    low = 0; g = 0;
    tgt_done = 1'b0; tgt_busy = 1'b0; tgt_init_n = 1'b1;
    pulse_start();
    while (!tgt_prog_n && g < 1000) begin
      low++; g++;
      if (drop && low == 2) tgt_init_n = 1'b0;
      step();
    end
    if (rise) begin
      repeat (3) step();
      tgt_init_n = 1'b1;
    end
  endtask

  task automatic feed(input logic [7:0] b, input bit last);
    int g;
    g = 0;
    s_valid = 1'b1; s_data = b; s_last = last;
    while (!s_ready && g < 1000) begin step(); g++; end
    step();
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int g;
    g = 0;
    while (active && g < 2000) begin step(); g++; end
    chk(req, "run ends", active, 0);
  endtask

  task automatic busy_bumps(input int n);
    for (int k = 0; k < n; k++) begin
      int g, lo;
      g = 0; lo = 0;
      while (tgt_cclk && g < 1000) begin step(); g++; end
      while (!tgt_cclk && g < 1000) begin step(); lo++; g++; end
      if (k == 0) lo_meas = lo;
      tgt_busy = 1'b1;
      repeat (6) step();
      tgt_busy = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1", "prog_n", tgt_prog_n, 1);
    chk("R1", "sel_n/wr_n/cclk", {tgt_sel_n, tgt_wr_n, tgt_cclk}, 3'b111);
    chk("R1", "ready/active", {s_ready, active}, 2'b00);
    chk("R1", "ok/err", {cfg_ok, cfg_err}, 2'b00);
  endtask

  task automatic t_normal();
    logic [7:0] pat [5];
    int low, base, settle, gap, g, bad0, mism;
    pat[0] = 8'hA5; pat[1] = 8'h3C; pat[2] = 8'h00; pat[3] = 8'hFF; pat[4] = 8'h5A;
    base = cap_total; bad0 = stall_bad;
    prog_phase(1'b1, 1'b1, low);
    chk("R2", "program pulse >= min", (low >= PROG_CYC), 1);
    chk("R2", "program pulse length", low, PROG_CYC);
    g = 0;
    while (tgt_sel_n && g < 1000) begin step(); g++; end
    chk("R4", "wr_n low with sel_n", tgt_wr_n, 0);
    settle = 0;
    while (!s_ready && g < 1000) begin step(); settle++; g++; end
    chk("R4", "settle cycles", settle, SET_CYC);
    fork
      for (int i = 0; i < 5; i++) feed(pat[i], i == 4);
      busy_bumps(5);
    join
    gap = 0; g = 0;
    while (!tgt_wr_n && g < 1000) begin
      if (tgt_sel_n) gap++;
      step(); g++;
    end
    chk("R9", "sel_n high before wr_n", gap, 1);
    tgt_done = 1'b1;
    wait_idle("R10");
    chk("R5", "bytes clocked", cap_total - base, 5);
    mism = 0;
    for (int i = 0; i < 5; i++) if (cap[(base + i) % 64] != pat[i]) mism++;
    chk("R5", "byte values on bus", mism, 0);
    chk("R5", "clock low cycles", lo_meas, LO_CYC);
    chk("R8", "no accept while busy", stall_bad - bad0, 0);
    chk("R10", "cfg_ok", cfg_ok, 1);
    chk("R10", "err_code", err_code, 0);
    tgt_done = 1'b0;
  endtask

  task automatic t_no_init_low();
    int low;
    prog_phase(1'b0, 1'b0, low);
    wait_idle("R2");
    chk("R2", "program low until limit", low, INIT_CYC);
    chk("R2", "code no init low", err_code, 1);
    chk("R11", "pins released", {tgt_prog_n, tgt_sel_n, tgt_wr_n}, 3'b111);
    chk("R11", "cfg_err", cfg_err, 1);
  endtask

  task automatic t_init_high_to();
    int low;
    prog_phase(1'b1, 1'b0, low);
    wait_idle("R3");
    chk("R3", "code init high timeout", err_code, 2);
    tgt_init_n = 1'b1;
  endtask

  task automatic t_bitstream_err();
    int low, base;
    base = cap_total;
    prog_phase(1'b1, 1'b1, low);
    feed(8'h11, 1'b0); feed(8'h22, 1'b0); feed(8'h33, 1'b0);
    tgt_init_n = 1'b0;
    s_valid = 1'b1; s_data = 8'h77;
    wait_idle("R7");
    s_valid = 1'b0;
    chk("R7", "code bitstream error", err_code, 3);
    chk("R7", "err_offset", err_offset, 3);
    chk("R7", "no byte after error", cap_total - base, 3);
    chk("R11", "sel_n/wr_n released", {tgt_sel_n, tgt_wr_n}, 2'b11);
    tgt_init_n = 1'b1;
  endtask

  task automatic t_busy_to();
    int low, base;
    base = cap_total;
    prog_phase(1'b1, 1'b1, low);
    feed(8'h9C, 1'b0);
    tgt_busy = 1'b1;
    s_valid = 1'b1; s_data = 8'h44;
    wait_idle("R8");
    s_valid = 1'b0; tgt_busy = 1'b0;
    chk("R8", "code busy timeout", err_code, 4);
    chk("R8", "one byte clocked", cap_total - base, 1);
    chk("R8", "err_offset", err_offset, 1);
  endtask

  task automatic t_early_done();
    int low, base;
    base = cap_total;
    prog_phase(1'b1, 1'b1, low);
    feed(8'hC1, 1'b0); feed(8'hC2, 1'b0);
    tgt_done = 1'b1;
    s_valid = 1'b1; s_data = 8'hC3;
    wait_idle("R6");
    s_valid = 1'b0;
    chk("R6", "byte after done ignored", cap_total - base, 2);
    chk("R6", "cfg_ok after early done", cfg_ok, 1);
    chk("R6", "no error", cfg_err, 0);
    tgt_done = 1'b0;
  endtask

  task automatic t_done_to();
    int low;
    prog_phase(1'b1, 1'b1, low);
    feed(8'hE7, 1'b1);
    wait_idle("R10");
    chk("R10", "code done timeout", err_code, 5);
    chk("R10", "cfg_ok low", cfg_ok, 0);
  endtask

  task automatic t_sticky_restart();
    repeat (5) step();
    chk("R11", "status held while idle", {cfg_err, err_code}, {1'b1, 3'd5});
    tgt_init_n = 1'b1;
    pulse_start();
    chk("R11", "start clears status", {active, cfg_err, err_code}, {1'b1, 1'b0, 3'd0});
    wait_idle("R11");
    chk("R11", "new cause recorded", err_code, 1);
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) step();
    t_reset();
    rst_n = 1'b1;
    repeat (2) step();
    t_reset();
    t_normal();
    t_no_init_low();
    t_init_high_to();
    t_bitstream_err();
    t_busy_to();
    t_early_done();
    t_done_to();
    t_sticky_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule